// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write path of a byte-wide flash array. It takes one bus write per cycle (address and data byte) and decides which command the host is issuing. Commands are entered through multi-cycle unlock sequences. The decoder then tells the read path what a bus read should return: array data, identifier bytes, or status. It sends single-cycle start, suspend, resume and abort pulses to the program/erase controller, together with the target address, the data byte and the set of blocks to erase.

The decoder supports several command families:
- read/reset and auto select;
- byte program, plus a bypass mode that shortens each program to two writes;
- chip erase;
- multi-block erase, whose add-block window restarts on each added block and is counted in clock cycles;
- erase suspend and resume.

Protected blocks are given as an input mask. The decoder never starts a program inside a protected block and never places a protected block in an erase set. The block index is the top `BLK_BITS` bits of the address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (array), `bypass_o` is 0, every pulse output is 0, and `erase_mask_o`, `tgt_addr_o` and `tgt_data_o` are 0.
- R2: Only bits [10:0] of `wr_addr` take part in command matching. Unlock cycles with any value in the upper bits behave the same.
- R3: The write sequence AA@555, 55@2AA, 90@555 sets `mode_o` to 1 (identifier). In that mode `id_data_o` is 20h for `id_off`=0, `DEV_ID` for 1, 01h/00h for 2 (protection of block `id_blk`), and 00h for 3.
- R4: A write that does not continue a valid sequence returns `mode_o` to 0. A single F0 write, or F0 after the AA/55 pair, also returns it to 0, including from identifier mode.
- R5: AA, 55, A0@555, then a write of address/data to an unprotected block gives `start_prog_o` high for one cycle, latches `tgt_addr_o`/`tgt_data_o` and sets `mode_o` to 2 (status). Writes are ignored until `pec_done`, which returns the decoder to array mode.
- R6: A program whose address lies in a protected block gives no pulse. The decoder returns to the mode it came from (array, or bypass).
- R7: AA, 55, 20@555 sets `bypass_o`. In bypass, A0 followed by address/data starts a program, and completion returns to bypass. 90 followed by 00 clears `bypass_o`. Any other write leaves bypass unchanged.
- R8: AA, 55, 80@555, AA, 55, 10@555 pulses `start_erase_o` at once, with `erase_mask_o` equal to the inverse of `prot_mask`. While this chip erase runs, B0 and F0 are ignored.
- R9: The same prefix ending in 30 at any address opens an add-block window of `WIN_CYCLES` cycles (status mode). Each further 30 write adds its block and restarts the window. `start_erase_o` pulses `WIN_CYCLES` cycles after the last add. Protected blocks are left out of the mask, and an all-protected set still starts with an empty mask.
- R10: During a running block erase, B0 pulses `suspend_o` and sets array mode. In suspend, 30 pulses `resume_o` and sets status mode. Other writes in suspend are ignored.
- R11: B0 inside the add-block window suspends without a pulse. A following 30 pulses `start_erase_o` at once, and no further blocks can be added.
- R12: F0 during a running block erase pulses `abort_o`, clears `erase_mask_o` and sets array mode. `pec_done` during an erase also returns to array mode with the mask cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| pec_done | input | 1 | Program/erase controller finished |
| prot_mask | input | NUM_BLK | One bit per block, 1 = protected |
| id_off | input | 2 | Read offset used in identifier mode |
| id_blk | input | BLK_BITS | Block addressed by an identifier read |
| mode_o | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| bypass_o | output | 1 | Bypass mode active |
| start_prog_o | output | 1 | Start byte program pulse |
| start_erase_o | output | 1 | Start erase pulse |
| suspend_o | output | 1 | Suspend erase pulse |
| resume_o | output | 1 | Resume erase pulse |
| abort_o | output | 1 | Abort erase pulse |
| tgt_addr_o | output | ADDR_W | Latched program address |
| tgt_data_o | output | 8 | Latched program data |
| erase_mask_o | output | NUM_BLK | Blocks selected for erase |
| id_data_o | output | 8 | Identifier-mode read data |

## Verification
A wrong sequencer state shows up on `mode_o` or `bypass_o` in the cycle after the offending write, because both decode directly from the registered state. Missing or extra pulses are seen on the first edge after the accepting write. Window timing faults show up as a `start_erase_o` that arrives early or late relative to the last added block, so the bench compares every output against its model on every cycle. Protection mistakes appear either as a start pulse that should not occur or as a wrong bit in `erase_mask_o`.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int MATCH_W = 11;
    localparam logic [MATCH_W-1:0] ADR_CMD = 11'h555;
    localparam logic [MATCH_W-1:0] ADR_ALT = 11'h2AA;

    localparam logic [7:0] D_KEY1   = 8'hAA;
    localparam logic [7:0] D_KEY2   = 8'h55;
    localparam logic [7:0] D_IDENT  = 8'h90;
    localparam logic [7:0] D_PROG   = 8'hA0;
    localparam logic [7:0] D_BYPASS = 8'h20;
    localparam logic [7:0] D_ESETUP = 8'h80;
    localparam logic [7:0] D_CHIP   = 8'h10;
    localparam logic [7:0] D_BLOCK  = 8'h30;
    localparam logic [7:0] D_SUSP   = 8'hB0;
    localparam logic [7:0] D_RESET  = 8'hF0;
    localparam logic [7:0] D_BYEXIT = 8'h00;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_ID     = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [3:0] {
        S_READ, S_UL1, S_UL2, S_ASEL,
        S_PGM_ARG, S_PGM_BUSY,
        S_BYP, S_BYP_ARG, S_BYP_EXIT,
        S_ERS_SET, S_ERS_UL1, S_ERS_UL2,
        S_ERS_WIN, S_ERS_BUSY, S_ERS_SUSP
    } seq_state_e;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              key1_hit,
    output logic              key2_hit,
    output logic              at_cmd
);
    logic [MATCH_W-1:0] low_bits;

    assign low_bits = addr[MATCH_W-1:0];
    assign at_cmd   = (low_bits == ADR_CMD);
    assign key1_hit = at_cmd && (data == D_KEY1);
    assign key2_hit = (low_bits == ADR_ALT) && (data == D_KEY2);
endmodule

// File: rtl/fcd_erase_timer.sv
module fcd_erase_timer #(
    parameter int WIN_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(WIN_CYCLES);
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && !load && (cnt_q == CW'(1));

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WIN_CYCLES));

    assert_load_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == CW'(WIN_CYCLES));
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
    parameter int         BLK_BITS = 3,
    parameter logic [7:0] MFR_ID   = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'hB0,
    localparam int        NUM_BLK  = 1 << BLK_BITS
) (
    input  logic [1:0]          off,
    input  logic [BLK_BITS-1:0] blk,
    input  logic [NUM_BLK-1:0]  prot,
    output logic [7:0]          data
);
    always_comb begin
        case (off)
            2'd0:    data = MFR_ID;
            2'd1:    data = DEV_ID;
            2'd2:    data = {7'd0, prot[blk]};
            default: data = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W     = 18,
    parameter int         BLK_BITS   = 3,
    parameter int         WIN_CYCLES = 6250,
    parameter logic [7:0] MFR_ID     = 8'h20,
    parameter logic [7:0] DEV_ID     = 8'hB0,
    localparam int        NUM_BLK    = 1 << BLK_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                pec_done,
    input  logic [NUM_BLK-1:0]  prot_mask,
    input  logic [1:0]          id_off,
    input  logic [BLK_BITS-1:0] id_blk,
    output logic [1:0]          mode_o,
    output logic                bypass_o,
    output logic                start_prog_o,
    output logic                start_erase_o,
    output logic                suspend_o,
    output logic                resume_o,
    output logic                abort_o,
    output logic [ADDR_W-1:0]   tgt_addr_o,
    output logic [7:0]          tgt_data_o,
    output logic [NUM_BLK-1:0]  erase_mask_o,
    output logic [7:0]          id_data_o
);
    typedef struct packed {
        seq_state_e          st;
        logic                ret_byp;
        logic                chip;
        logic                frozen;
        logic [NUM_BLK-1:0]  mask;
        logic [ADDR_W-1:0]   taddr;
        logic [7:0]          tdata;
        logic                go_prog;
        logic                go_erase;
        logic                go_susp;
        logic                go_resume;
        logic                go_abort;
    } dec_t;

    dec_t r_d, r_q;

    logic                key1_hit, key2_hit, at_cmd;
    logic [BLK_BITS-1:0] wr_blk;
    logic [NUM_BLK-1:0]  wr_hot;
    logic                wr_prot;
    logic                tmr_load, tmr_run, tmr_expire;

    fcd_cycle_match #(.ADDR_W(ADDR_W)) u_match (
        .addr     (wr_addr),
        .data     (wr_data),
        .key1_hit (key1_hit),
        .key2_hit (key2_hit),
        .at_cmd   (at_cmd)
    );

    fcd_erase_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (tmr_run),
        .expire (tmr_expire)
    );

    fcd_id_mux #(.BLK_BITS(BLK_BITS), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .off  (id_off),
        .blk  (id_blk),
        .prot (prot_mask),
        .data (id_data_o)
    );

    assign wr_blk  = wr_addr[ADDR_W-1 -: BLK_BITS];
    assign wr_hot  = NUM_BLK'(1) << wr_blk;
    assign wr_prot = prot_mask[wr_blk];
    assign tmr_run = (r_q.st == S_ERS_WIN);

    always_comb begin
        r_d           = r_q;
        r_d.go_prog   = 1'b0;
        r_d.go_erase  = 1'b0;
        r_d.go_susp   = 1'b0;
        r_d.go_resume = 1'b0;
        r_d.go_abort  = 1'b0;
        tmr_load      = 1'b0;

        case (r_q.st)
            S_READ, S_ASEL: begin
                if (wr_en) r_d.st = key1_hit ? S_UL1 : S_READ;
            end
            S_UL1: begin
                if (wr_en) r_d.st = key2_hit ? S_UL2 : S_READ;
            end
            S_UL2: begin
                if (wr_en) begin
                    r_d.st = S_READ;
                    if (at_cmd) begin
                        case (wr_data)
                            D_IDENT:  r_d.st = S_ASEL;
                            D_PROG:   r_d.st = S_PGM_ARG;
                            D_BYPASS: r_d.st = S_BYP;
                            D_ESETUP: r_d.st = S_ERS_SET;
                            default:  r_d.st = S_READ;
                        endcase
                    end
                end
            end
            S_PGM_ARG, S_BYP_ARG: begin
                if (wr_en) begin
                    r_d.ret_byp = (r_q.st == S_BYP_ARG);
                    if (wr_prot) begin
                        r_d.st = (r_q.st == S_BYP_ARG) ? S_BYP : S_READ;
                    end else begin
                        r_d.st      = S_PGM_BUSY;
                        r_d.go_prog = 1'b1;
                        r_d.taddr   = wr_addr;
                        r_d.tdata   = wr_data;
                    end
                end
            end
            S_PGM_BUSY: begin
                if (pec_done) r_d.st = r_q.ret_byp ? S_BYP : S_READ;
            end
            S_BYP: begin
                if (wr_en) begin
                    if (wr_data == D_PROG)       r_d.st = S_BYP_ARG;
                    else if (wr_data == D_IDENT) r_d.st = S_BYP_EXIT;
                end
            end
            S_BYP_EXIT: begin
                if (wr_en) r_d.st = (wr_data == D_BYEXIT) ? S_READ : S_BYP;
            end
            S_ERS_SET: begin
                if (wr_en) r_d.st = key1_hit ? S_ERS_UL1 : S_READ;
            end
            S_ERS_UL1: begin
                if (wr_en) r_d.st = key2_hit ? S_ERS_UL2 : S_READ;
            end
            S_ERS_UL2: begin
                if (wr_en) begin
                    if (at_cmd && wr_data == D_CHIP) begin
                        r_d.st       = S_ERS_BUSY;
                        r_d.chip     = 1'b1;
                        r_d.frozen   = 1'b0;
                        r_d.mask     = ~prot_mask;
                        r_d.go_erase = 1'b1;
                    end else if (wr_data == D_BLOCK) begin
                        r_d.st     = S_ERS_WIN;
                        r_d.chip   = 1'b0;
                        r_d.frozen = 1'b0;
                        r_d.mask   = wr_prot ? '0 : wr_hot;
                        tmr_load   = 1'b1;
                    end else begin
                        r_d.st = S_READ;
                    end
                end
            end
            S_ERS_WIN: begin
                if (wr_en && wr_data == D_RESET) begin
                    r_d.st   = S_READ;
                    r_d.mask = '0;
                end else if (wr_en && wr_data == D_SUSP) begin
                    r_d.st     = S_ERS_SUSP;
                    r_d.frozen = 1'b1;
                end else if (wr_en && wr_data == D_BLOCK) begin
                    if (!wr_prot) r_d.mask = r_q.mask | wr_hot;
                    tmr_load = 1'b1;
                end else if (tmr_expire) begin
                    r_d.st       = S_ERS_BUSY;
                    r_d.go_erase = 1'b1;
                end
            end
            S_ERS_BUSY: begin
                if (pec_done) begin
                    r_d.st   = S_READ;
                    r_d.mask = '0;
                end else if (wr_en && !r_q.chip) begin
                    if (wr_data == D_SUSP) begin
                        r_d.st      = S_ERS_SUSP;
                        r_d.go_susp = 1'b1;
                    end else if (wr_data == D_RESET) begin
                        r_d.st       = S_READ;
                        r_d.mask     = '0;
                        r_d.go_abort = 1'b1;
                    end
                end
            end
            S_ERS_SUSP: begin
                if (wr_en && wr_data == D_BLOCK) begin
                    r_d.st = S_ERS_BUSY;
                    if (r_q.frozen) begin
                        r_d.frozen   = 1'b0;
                        r_d.go_erase = 1'b1;
                    end else begin
                        r_d.go_resume = 1'b1;
                    end
                end
            end
            default: r_d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_READ;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            S_ASEL:                            mode_o = RM_ID;
            S_PGM_BUSY, S_ERS_WIN, S_ERS_BUSY: mode_o = RM_STATUS;
            default:                           mode_o = RM_ARRAY;
        endcase
    end

    assign bypass_o = (r_q.st == S_BYP) || (r_q.st == S_BYP_ARG) ||
                      (r_q.st == S_BYP_EXIT) ||
                      ((r_q.st == S_PGM_BUSY) && r_q.ret_byp);

    assign start_prog_o  = r_q.go_prog;
    assign start_erase_o = r_q.go_erase;
    assign suspend_o     = r_q.go_susp;
    assign resume_o      = r_q.go_resume;
    assign abort_o       = r_q.go_abort;
    assign tgt_addr_o    = r_q.taddr;
    assign tgt_data_o    = r_q.tdata;
    assign erase_mask_o  = r_q.mask;

    assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog_o, start_erase_o, suspend_o, resume_o, abort_o}));

    assert_prog_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog_o |-> mode_o == RM_STATUS);

    assert_prog_target_in_open_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog_o |-> !prot_mask[tgt_addr_o[ADDR_W-1 -: BLK_BITS]] || !$stable(prot_mask));

    assert_bypass_no_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_o |-> mode_o != RM_ID);

    assert_erase_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase_o |-> mode_o == RM_STATUS);

    assert_suspend_array_R10: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> mode_o == RM_ARRAY);

    assert_resume_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> mode_o == RM_STATUS);

    assert_abort_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (erase_mask_o == '0 && mode_o == RM_ARRAY));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int AW  = 18;
    localparam int WIN = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pec_done = 1'b0;
    logic [7:0]  prot_mask = 8'b0000_0100;
    logic [1:0]  id_off = '0;
    logic [2:0]  id_blk = '0;
    logic [1:0]  mode_o;
    logic        bypass_o, start_prog_o, start_erase_o, suspend_o, resume_o, abort_o;
    logic [17:0] tgt_addr_o;
    logic [7:0]  tgt_data_o, erase_mask_o, id_data_o;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .BLK_BITS(3), .WIN_CYCLES(WIN),
                        .MFR_ID(8'h20), .DEV_ID(8'hB0)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pec_done(pec_done), .prot_mask(prot_mask), .id_off(id_off), .id_blk(id_blk),
        .mode_o(mode_o), .bypass_o(bypass_o), .start_prog_o(start_prog_o),
        .start_erase_o(start_erase_o), .suspend_o(suspend_o), .resume_o(resume_o),
        .abort_o(abort_o), .tgt_addr_o(tgt_addr_o), .tgt_data_o(tgt_data_o),
        .erase_mask_o(erase_mask_o), .id_data_o(id_data_o)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference: phase names as strings, window as an integer countdown
    string m_ph;
    bit    m_ret, m_chip, m_frz, m_byp;
    bit [7:0]  m_mask, m_tdata;
    bit [17:0] m_taddr;
    bit [4:0]  m_pulse;   // {prog, erase, susp, resume, abort}
    int    m_cnt;

    function automatic bit key1(input bit [17:0] a, input bit [7:0] d);
        return (a % 2048 == 'h555) && d == 8'hAA;
    endfunction
    function automatic bit key2(input bit [17:0] a, input bit [7:0] d);
        return (a % 2048 == 'h2AA) && d == 8'h55;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = "read"; m_ret = 0; m_chip = 0; m_frz = 0;
            m_mask = 0; m_tdata = 0; m_taddr = 0; m_pulse = 0; m_cnt = 0;
        end else begin
            int blk;
            bit w;
            w = wr_en;
            blk = int'(wr_addr) / 32768;
            m_pulse = 0;
            if (m_ph == "read" || m_ph == "asel") begin
                if (w) m_ph = key1(wr_addr, wr_data) ? "u1" : "read";
            end else if (m_ph == "u1") begin
                if (w) m_ph = key2(wr_addr, wr_data) ? "u2" : "read";
            end else if (m_ph == "u2") begin
                if (w) begin
                    m_ph = "read";
                    if (wr_addr % 2048 == 'h555) begin
                        if (wr_data == 8'h90) m_ph = "asel";
                        if (wr_data == 8'hA0) m_ph = "parg";
                        if (wr_data == 8'h20) m_ph = "byp";
                        if (wr_data == 8'h80) m_ph = "eset";
                    end
                end
            end else if (m_ph == "parg" || m_ph == "barg") begin
                if (w) begin
                    m_ret = (m_ph == "barg");
                    if (prot_mask[blk]) m_ph = m_ret ? "byp" : "read";
                    else begin
                        m_ph = "pbusy"; m_pulse = 5'b10000;
                        m_taddr = wr_addr; m_tdata = wr_data;
                    end
                end
            end else if (m_ph == "pbusy") begin
                if (pec_done) m_ph = m_ret ? "byp" : "read";
            end else if (m_ph == "byp") begin
                if (w && wr_data == 8'hA0) m_ph = "barg";
                else if (w && wr_data == 8'h90) m_ph = "bexit";
            end else if (m_ph == "bexit") begin
                if (w) m_ph = (wr_data == 8'h00) ? "read" : "byp";
            end else if (m_ph == "eset") begin
                if (w) m_ph = key1(wr_addr, wr_data) ? "e1" : "read";
            end else if (m_ph == "e1") begin
                if (w) m_ph = key2(wr_addr, wr_data) ? "e2" : "read";
            end else if (m_ph == "e2") begin
                if (w) begin
                    if (wr_addr % 2048 == 'h555 && wr_data == 8'h10) begin
                        m_ph = "ebusy"; m_chip = 1; m_frz = 0; m_mask = ~prot_mask; m_pulse = 5'b01000;
                    end else if (wr_data == 8'h30) begin
                        m_ph = "ewin"; m_chip = 0; m_frz = 0; m_cnt = WIN;
                        m_mask = prot_mask[blk] ? 8'h00 : (8'h01 << blk);
                    end else m_ph = "read";
                end
            end else if (m_ph == "ewin") begin
                if (w && wr_data == 8'hF0) begin m_ph = "read"; m_mask = 0; end
                else if (w && wr_data == 8'hB0) begin m_ph = "susp"; m_frz = 1; end
                else if (w && wr_data == 8'h30) begin
                    if (!prot_mask[blk]) m_mask[blk] = 1'b1;
                    m_cnt = WIN;
                end else if (m_cnt == 1) begin m_ph = "ebusy"; m_pulse = 5'b01000; end
                else m_cnt = m_cnt - 1;
            end else if (m_ph == "ebusy") begin
                if (pec_done) begin m_ph = "read"; m_mask = 0; end
                else if (w && !m_chip && wr_data == 8'hB0) begin m_ph = "susp"; m_pulse = 5'b00100; end
                else if (w && !m_chip && wr_data == 8'hF0) begin m_ph = "read"; m_mask = 0; m_pulse = 5'b00001; end
            end else if (m_ph == "susp") begin
                if (w && wr_data == 8'h30) begin
                    m_ph = "ebusy";
                    if (m_frz) begin m_frz = 0; m_pulse = 5'b01000; end
                    else m_pulse = 5'b00010;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [1:0] em;
            logic [7:0] eid;
            em = (m_ph == "asel") ? 2'd1 :
                 (m_ph == "pbusy" || m_ph == "ewin" || m_ph == "ebusy") ? 2'd2 : 2'd0;
            case (id_off)
                2'd0: eid = 8'h20;
                2'd1: eid = 8'hB0;
                2'd2: eid = prot_mask[id_blk] ? 8'h01 : 8'h00;
                default: eid = 8'h00;
            endcase
            m_byp = (m_ph == "byp" || m_ph == "barg" || m_ph == "bexit" || (m_ph == "pbusy" && m_ret));
            chk("mode", 32'(mode_o), 32'(em));
            chk("bypass", 32'(bypass_o), 32'(m_byp));
            chk("pulses", 32'({start_prog_o, start_erase_o, suspend_o, resume_o, abort_o}), 32'(m_pulse));
            chk("tgt_addr", 32'(tgt_addr_o), 32'(m_taddr));
            chk("tgt_data", 32'(tgt_data_o), 32'(m_tdata));
            chk("erase_mask", 32'(erase_mask_o), 32'(m_mask));
            chk("id_data", 32'(id_data_o), 32'(eid));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask
    task automatic done_pulse();
        pec_done = 1'b1; tick(1); pec_done = 1'b0;
    endtask
    task automatic unlock();
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
    endtask
    task automatic want_pulse(input string what, input logic act, input logic exp);
        tick(0);
        chk(what, 32'(act), 32'(exp));
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        @(posedge clk); #1;
        cur_req = "R1";
        tick(3);

        // R2 R3: upper address bits differ, identifier mode entered
        cur_req = "R2";
        wr(18'h3D555, 8'hAA); wr(18'h2AAAA, 8'h55); wr(18'h1F555, 8'h90);
        cur_req = "R3";
        tick(1);
        chk("R3 mode after ident", 32'(mode_o), 32'd1);
        for (int o = 0; o < 4; o++) begin id_off = 2'(o); tick(1); end
        id_off = 2'd2; id_blk = 3'd2; tick(1);
        chk("R3 protected block id", 32'(id_data_o), 32'h01);
        id_blk = 3'd5; tick(1);
        id_off = 2'd0;

        // R4: F0 leaves identifier mode; broken sequences
        cur_req = "R4";
        wr(18'h00000, 8'hF0);
        chk("R4 mode after F0", 32'(mode_o), 32'd0);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h56); wr(18'h00555, 8'h90); tick(2);
        chk("R4 broken sequence", 32'(mode_o), 32'd0);
        unlock(); wr(18'h00555, 8'hF0); tick(1);
        unlock(); wr(18'h00444, 8'h90); tick(1);
        chk("R4 wrong command address", 32'(mode_o), 32'd0);

        // R5: program an open block, writes ignored while busy
        cur_req = "R5";
        unlock(); wr(18'h00555, 8'hA0); wr(18'h05123, 8'h3C);
        chk("R5 start_prog", 32'(start_prog_o), 32'd1);
        wr(18'h00000, 8'hF0); wr(18'h00555, 8'hAA); tick(3);
        chk("R5 still status", 32'(mode_o), 32'd2);
        done_pulse(); tick(2);

        // R6: program into protected block 2
        cur_req = "R6";
        unlock(); wr(18'h00555, 8'hA0); wr(18'h10004, 8'h77); tick(3);

        // R7: bypass mode
        cur_req = "R7";
        unlock(); wr(18'h00555, 8'h20); tick(1);
        wr(18'h00123, 8'h55); tick(1);
        wr(18'h00000, 8'hA0); wr(18'h3FFFF, 8'h81);
        tick(2); done_pulse(); tick(1);
        chk("R7 back in bypass", 32'(bypass_o), 32'd1);
        cur_req = "R6";
        wr(18'h00000, 8'hA0); wr(18'h12345, 8'h11); tick(1);
        cur_req = "R7";
        wr(18'h00000, 8'h90); wr(18'h00000, 8'h01); tick(1);
        wr(18'h00000, 8'h90); wr(18'h00000, 8'h00); tick(1);
        chk("R7 bypass exit", 32'(bypass_o), 32'd0);

        // R8: chip erase; suspend and reset ignored
        cur_req = "R8";
        unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h00555, 8'h10);
        chk("R8 start_erase", 32'(start_erase_o), 32'd1);
        wr(18'h00000, 8'hB0); wr(18'h00000, 8'hF0); tick(2);
        done_pulse(); tick(2);

        // R9: block erase with restart of the window
        cur_req = "R9";
        unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h08000, 8'h30);
        tick(WIN - 5);
        wr(18'h18000, 8'h30);
        tick(WIN - 10);
        wr(18'h10000, 8'h30);
        tick(WIN + 3);
        chk("R9 mask", 32'(erase_mask_o), 32'h0A);
        wr(18'h20000, 8'h30); tick(2);
        // R10: suspend / resume, then R12 completion
        cur_req = "R10";
        wr(18'h00000, 8'hB0);
        chk("R10 suspend pulse", 32'(suspend_o), 32'd1);
        wr(18'h00000, 8'h55); tick(2);
        wr(18'h00000, 8'h30);
        chk("R10 resume pulse", 32'(resume_o), 32'd1);
        cur_req = "R12";
        tick(2); done_pulse(); tick(2);

        // R12: abort during running erase
        unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h30000, 8'h30);
        tick(WIN + 2);
        wr(18'h00000, 8'hF0);
        chk("R12 abort pulse", 32'(abort_o), 32'd1);
        tick(2);

        // R11: suspend inside window, resume starts at once
        cur_req = "R11";
        unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h28000, 8'h30);
        tick(5);
        wr(18'h00000, 8'hB0); tick(WIN + 4);
        chk("R11 no start while frozen", 32'(mode_o), 32'd0);
        wr(18'h00000, 8'h30);
        chk("R11 immediate start", 32'(start_erase_o), 32'd1);
        wr(18'h38000, 8'h30); tick(2);
        chk("R11 no block added", 32'(erase_mask_o), 32'h20);
        done_pulse(); tick(2);

        // R9: every selected block protected
        cur_req = "R9";
        unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h10000, 8'h30);
        tick(WIN + 3);
        done_pulse(); tick(3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL %s watchdog actual=%0d expected=done", cur_req, cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule